// File: doc/BRIEF.md
# SPI FIFO Pair with Watermark Interrupts

This block holds the data path buffering of a serial peripheral controller. It has two first-in first-out stores, one carrying words from the register bus to the serial engine (transmit) and one carrying words from the serial engine back to the bus (receive). Each store is 32 words deep and reports its fill count. The fill counts are compared against two programmable watermarks, and the results drive a small interrupt unit.

The interrupt unit holds three sticky error flags: transmit overflow, receive overflow and receive underflow. It also has two level-sensitive watermark flags. The raw flag vector is gated by a mask register and reduced to a single interrupt line. Software clears the error flags by writing ones to a clear strobe. A status vector reports full and empty for both stores, together with a busy indication taken from the serial engine.

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset both stores are empty (levels 0), the mask is 0, every sticky flag is 0 and `irq` is low; with a transmit watermark of 0 the raw vector then reads 5'b00001.
- R2: Each store returns words in the order they were accepted, holds up to DEPTH (32) words, and its level (0 to 32) reflects a push or pop from the clock edge that accepts it.
- R3: A push into a full store is dropped without changing its level or contents, and sets the sticky overflow flag: raw bit 1 for transmit, raw bit 3 for receive.
- R4: A pop from an empty store returns 0 and leaves the level at 0; on the receive store it also sets the sticky underflow flag, raw bit 2.
- R5: Sticky flags stay set until cleared by `clr_wr` with `clr_bits` bit 3 (transmit overflow), bit 2 (receive overflow), bit 1 (receive underflow) or bit 0 (all three); an error in the same cycle as its clear leaves the flag set.
- R6: Raw bit 4 is 1 exactly while the receive level is at least the receive watermark plus one.
- R7: Raw bit 0 is 1 exactly while the transmit level is at or below the transmit watermark, so a watermark of 0 flags only an empty store.
- R8: `mask_wr` loads `mask_val` into the mask register; `masked_irq` is the raw vector ANDed with that mask (same bit order), and `irq` is the OR of `masked_irq`.
- R9: `status` reads bit 4 receive full, bit 3 receive empty, bit 2 transmit empty, bit 1 transmit full, bit 0 the `engine_busy` input.
- R10: A push and a pop in the same cycle on a store that is neither empty nor full keep its level unchanged and deliver the head word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_push | input | 1 | Bus writes a word into the transmit store |
| tx_push_data | input | DW | Word written into the transmit store |
| tx_pop | input | 1 | Serial engine takes the transmit head word |
| tx_pop_data | output | DW | Transmit head word (0 when empty) |
| rx_push | input | 1 | Serial engine writes a received word |
| rx_push_data | input | DW | Received word |
| rx_pop | input | 1 | Bus takes the receive head word |
| rx_pop_data | output | DW | Receive head word (0 when empty) |
| tx_mark | input | MARK_W | Transmit watermark |
| rx_mark | input | MARK_W | Receive watermark |
| mask_wr | input | 1 | Load strobe for the mask register |
| mask_val | input | 5 | New mask value |
| clr_wr | input | 1 | Clear strobe, write-one-to-clear |
| clr_bits | input | 4 | Clear selects |
| engine_busy | input | 1 | Serial engine busy indication |
| tx_level | output | LVL_W | Transmit fill count |
| rx_level | output | LVL_W | Receive fill count |
| status | output | 5 | Full/empty/busy status vector |
| raw_irq | output | 5 | Unmasked interrupt flags |
| masked_irq | output | 5 | Masked interrupt flags |
| irq | output | 1 | Combined interrupt line |

## Verification
Pop data, the watermark flags and the status vector are combinational from registered state. Pop data is therefore due in the same cycle as the pop strobe, and a watermark change is due right after the edge that moves the level. Levels, sticky flags and the mask all update on the edge that accepts the strobe. The bench drives every strobe at a falling edge. It reads pop data one time unit later, before the capturing edge. It reads levels and flags at the next falling edge, which is one register stage after the stimulus. Transmit and receive words go through scoreboard queues, so ordering and drop behaviour are judged against what the bench itself expects to be stored.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

    localparam int IRQ_W = 5;
    localparam int CLR_W = 4;
    localparam int ST_W  = 5;

    // raw / mask / masked flag positions
    localparam int IRQ_TX_LOW  = 0;
    localparam int IRQ_TX_OVF  = 1;
    localparam int IRQ_RX_UNF  = 2;
    localparam int IRQ_RX_OVF  = 3;
    localparam int IRQ_RX_HIGH = 4;

    // clear strobe positions
    localparam int CLR_ALL    = 0;
    localparam int CLR_RX_UNF = 1;
    localparam int CLR_RX_OVF = 2;
    localparam int CLR_TX_OVF = 3;

    // status positions
    localparam int ST_BUSY     = 0;
    localparam int ST_TX_FULL  = 1;
    localparam int ST_TX_EMPTY = 2;
    localparam int ST_RX_EMPTY = 3;
    localparam int ST_RX_FULL  = 4;

    typedef struct packed {
        logic [IRQ_W-1:0] mask;
        logic             tx_ovf;
        logic             rx_ovf;
        logic             rx_unf;
    } irq_state_t;

endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    pop_data,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             ovf_pulse,
    output logic             unf_pulse
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PTR_W-1:0]         wr;
        logic [PTR_W-1:0]         rd;
        logic [LVL_W-1:0]         cnt;
    } fifo_state_t;

    fifo_state_t st_q, st_d;
    logic        push_ok, pop_ok;

    always_comb begin
        full      = (st_q.cnt == LVL_W'(DEPTH));
        empty     = (st_q.cnt == '0);
        push_ok   = push && !full;
        pop_ok    = pop && !empty;
        ovf_pulse = push && full;
        unf_pulse = pop && empty;
        pop_data  = empty ? '0 : st_q.mem[st_q.rd];
        level     = st_q.cnt;

        st_d = st_q;
        if (push_ok) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sfi_irq.sv
module sfi_irq
    import sfi_pkg::*;
#(
    parameter int LVL_W  = 6,
    parameter int MARK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [MARK_W-1:0] tx_mark,
    input  logic [MARK_W-1:0] rx_mark,
    input  logic              tx_ovf_pulse,
    input  logic              rx_ovf_pulse,
    input  logic              rx_unf_pulse,
    input  logic              mask_wr,
    input  logic [IRQ_W-1:0]  mask_val,
    input  logic              clr_wr,
    input  logic [CLR_W-1:0]  clr_bits,
    output logic [IRQ_W-1:0]  raw,
    output logic [IRQ_W-1:0]  masked,
    output logic              irq
);

    localparam int CW = (LVL_W > MARK_W ? LVL_W : MARK_W) + 1;

    irq_state_t st_q, st_d;
    logic [CW-1:0] rx_need;
    logic          rx_hit, tx_hit;

    always_comb begin
        rx_need = CW'(rx_mark) + 1'b1;
        rx_hit  = CW'(rx_level) >= rx_need;
        tx_hit  = CW'(tx_level) <= CW'(tx_mark);

        st_d = st_q;
        if (mask_wr) st_d.mask = mask_val;
        if (clr_wr) begin
            if (clr_bits[CLR_ALL] || clr_bits[CLR_TX_OVF]) st_d.tx_ovf = 1'b0;
            if (clr_bits[CLR_ALL] || clr_bits[CLR_RX_OVF]) st_d.rx_ovf = 1'b0;
            if (clr_bits[CLR_ALL] || clr_bits[CLR_RX_UNF]) st_d.rx_unf = 1'b0;
        end
        // a fresh error outranks a clear in the same cycle
        if (tx_ovf_pulse) st_d.tx_ovf = 1'b1;
        if (rx_ovf_pulse) st_d.rx_ovf = 1'b1;
        if (rx_unf_pulse) st_d.rx_unf = 1'b1;

        raw              = '0;
        raw[IRQ_TX_LOW]  = tx_hit;
        raw[IRQ_TX_OVF]  = st_q.tx_ovf;
        raw[IRQ_RX_UNF]  = st_q.rx_unf;
        raw[IRQ_RX_OVF]  = st_q.rx_ovf;
        raw[IRQ_RX_HIGH] = rx_hit;
        masked           = raw & st_q.mask;
        irq              = |masked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
    import sfi_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DW     = 8,
    parameter int MARK_W = 5,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_push,
    input  logic [DW-1:0]     tx_push_data,
    input  logic              tx_pop,
    output logic [DW-1:0]     tx_pop_data,
    input  logic              rx_push,
    input  logic [DW-1:0]     rx_push_data,
    input  logic              rx_pop,
    output logic [DW-1:0]     rx_pop_data,
    input  logic [MARK_W-1:0] tx_mark,
    input  logic [MARK_W-1:0] rx_mark,
    input  logic              mask_wr,
    input  logic [4:0]        mask_val,
    input  logic              clr_wr,
    input  logic [3:0]        clr_bits,
    input  logic              engine_busy,
    output logic [LVL_W-1:0]  tx_level,
    output logic [LVL_W-1:0]  rx_level,
    output logic [4:0]        status,
    output logic [4:0]        raw_irq,
    output logic [4:0]        masked_irq,
    output logic              irq
);

    logic tx_full, tx_empty, tx_ovf_p, tx_unf_p;
    logic rx_full, rx_empty, rx_ovf_p, rx_unf_p;

    sfi_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .level     (tx_level),
        .full      (tx_full),
        .empty     (tx_empty),
        .ovf_pulse (tx_ovf_p),
        .unf_pulse (tx_unf_p)
    );

    sfi_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .pop_data  (rx_pop_data),
        .level     (rx_level),
        .full      (rx_full),
        .empty     (rx_empty),
        .ovf_pulse (rx_ovf_p),
        .unf_pulse (rx_unf_p)
    );

    sfi_irq #(.LVL_W(LVL_W), .MARK_W(MARK_W)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_level     (tx_level),
        .rx_level     (rx_level),
        .tx_mark      (tx_mark),
        .rx_mark      (rx_mark),
        .tx_ovf_pulse (tx_ovf_p),
        .rx_ovf_pulse (rx_ovf_p),
        .rx_unf_pulse (rx_unf_p),
        .mask_wr      (mask_wr),
        .mask_val     (mask_val),
        .clr_wr       (clr_wr),
        .clr_bits     (clr_bits),
        .raw          (raw_irq),
        .masked       (masked_irq),
        .irq          (irq)
    );

    // transmit side has no underflow flag; an empty pop just yields 0
    logic tx_unf_unused;
    assign tx_unf_unused = tx_unf_p;

    always_comb begin
        status              = '0;
        status[ST_BUSY]     = engine_busy;
        status[ST_TX_FULL]  = tx_full;
        status[ST_TX_EMPTY] = tx_empty;
        status[ST_RX_EMPTY] = rx_empty;
        status[ST_RX_FULL]  = rx_full;
    end

endmodule

// File: rtl/sfi_chk.sv
module sfi_chk #(
    parameter int DEPTH  = 32,
    parameter int DW     = 8,
    parameter int LVL_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_push,
    input logic             tx_pop,
    input logic             rx_push,
    input logic             rx_pop,
    input logic [DW-1:0]    rx_pop_data,
    input logic             clr_wr,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic [4:0]       status,
    input logic [4:0]       raw_irq,
    input logic [4:0]       masked_irq,
    input logic             irq
);

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

    // R3
    tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !tx_pop && tx_level == LVL_W'(DEPTH))
        |=> (tx_level == LVL_W'(DEPTH)) && raw_irq[1]);

    // R4
    rx_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_level == '0) |-> (rx_pop_data == '0));

    // R4
    rx_unf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && rx_level == '0) |=> raw_irq[2] && (rx_level == '0));

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_irq[3] && !clr_wr) |=> raw_irq[3]);

    // R8
    mask_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_irq & ~raw_irq) == 5'b0);

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_irq != 5'b0));

    // R9
    tx_full_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] == (tx_level == LVL_W'(DEPTH)));

    // R10
    rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_pop && rx_level != '0 && rx_level != LVL_W'(DEPTH))
        |=> $stable(rx_level));

endmodule

bind spi_fifo_irq sfi_chk #(.DEPTH(DEPTH), .DW(DW), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/tb_spi_fifo_irq.sv
module tb_spi_fifo_irq;

    localparam int DEPTH = 32;
    localparam int DW    = 8;
    localparam int LVL_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [DW-1:0]    tx_push_data = '0, rx_push_data = '0;
    logic [DW-1:0]    tx_pop_data, rx_pop_data;
    logic [4:0]       tx_mark = '0, rx_mark = '0;
    logic             mask_wr = 1'b0, clr_wr = 1'b0, engine_busy = 1'b0;
    logic [4:0]       mask_val = '0;
    logic [3:0]       clr_bits = '0;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic [4:0]       status, raw_irq, masked_irq;
    logic             irq;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] tx_q[$];
    logic [DW-1:0] rx_q[$];

    always #4 clk = ~clk;

    spi_fifo_irq dut (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // driver: push into transmit store, recording what should be kept
    task automatic tx_put(logic [DW-1:0] d, bit kept);
        tx_push = 1'b1; tx_push_data = d;
        if (kept) tx_q.push_back(d);
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic rx_put(logic [DW-1:0] d, bit kept);
        rx_push = 1'b1; rx_push_data = d;
        if (kept) rx_q.push_back(d);
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    // monitor side: take head and compare with scoreboard
    task automatic tx_take(string req);
        logic [DW-1:0] exp;
        tx_pop = 1'b1;
        #1;
        exp = (tx_q.size() != 0) ? tx_q.pop_front() : '0;
        chk(req, tx_pop_data, exp);
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic rx_take(string req);
        logic [DW-1:0] exp;
        rx_pop = 1'b1;
        #1;
        exp = (rx_q.size() != 0) ? rx_q.pop_front() : '0;
        chk(req, rx_pop_data, exp);
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic set_mask(logic [4:0] m);
        mask_wr = 1'b1; mask_val = m;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic clear(logic [3:0] b);
        clr_wr = 1'b1; clr_bits = b;
        @(negedge clk);
        clr_wr = 1'b0; clr_bits = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        wrap_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 raw", raw_irq, 5'b00001);
        chk("R1 irq", irq, 0);
        chk("R9 status after reset", status, 5'b01100);

        // R2 fill transmit store
        for (int i = 0; i < DEPTH; i++) tx_put(DW'(i * 3 + 1), 1'b1);
        chk("R2 tx_level full", tx_level, DEPTH);
        chk("R9 status tx full", status, 5'b01010);
        chk("R7 mark0 not empty", raw_irq[0], 0);

        // R3 overflow on transmit
        tx_put(8'hEE, 1'b0);
        chk("R3 tx_level kept", tx_level, DEPTH);
        chk("R3 tx ovf flag", raw_irq[1], 1);

        // R8 mask gates the line
        chk("R8 irq masked off", irq, 0);
        set_mask(5'b00010);
        chk("R8 masked", masked_irq, 5'b00010);
        chk("R8 irq on", irq, 1);

        // R5 wrong clear bit keeps flag, right one clears
        clear(4'b0100);
        chk("R5 tx ovf kept", raw_irq[1], 1);
        clear(4'b1000);
        chk("R5 tx ovf cleared", raw_irq[1], 0);
        chk("R5 irq low", irq, 0);

        // R2 drain in order, R7 watermark 4
        tx_mark = 5'd4;
        for (int i = 0; i < DEPTH; i++) begin
            tx_take("R2 tx order");
            if (tx_level >= 3 && tx_level <= 6)
                chk("R7 tx watermark", raw_irq[0], (tx_level <= 4) ? 1 : 0);
        end
        chk("R2 tx_level empty", tx_level, 0);

        // R4 transmit pop on empty: 0, no flag
        tx_take("R4 tx empty data");
        chk("R4 tx level stays", tx_level, 0);
        chk("R4 no tx flag", raw_irq[1], 0);

        // R6 receive watermark 2
        rx_mark = 5'd2;
        rx_put(8'h10, 1'b1);
        rx_put(8'h11, 1'b1);
        chk("R6 level2 below", raw_irq[4], 0);
        rx_put(8'h12, 1'b1);
        chk("R6 level3 reached", raw_irq[4], 1);
        rx_take("R2 rx order");
        chk("R6 drop back", raw_irq[4], 0);
        rx_take("R2 rx order");
        rx_take("R2 rx order");

        // R4 receive underflow
        rx_take("R4 rx empty data");
        chk("R4 rx unf flag", raw_irq[2], 1);
        chk("R4 rx level stays", rx_level, 0);

        // R3 receive overflow
        for (int i = 0; i < DEPTH; i++) rx_put(DW'(8'h40 + i), 1'b1);
        chk("R9 status rx full", status[4], 1);
        rx_put(8'hAB, 1'b0);
        chk("R3 rx ovf flag", raw_irq[3], 1);
        chk("R3 rx level kept", rx_level, DEPTH);
        set_mask(5'b01100);
        chk("R8 masked errors", masked_irq, 5'b01100);
        chk("R8 irq errors", irq, 1);

        // R5 clear-all
        clear(4'b0001);
        chk("R5 clear all raw", raw_irq[3:1], 0);
        chk("R5 clear all irq", irq, 0);

        // R10 simultaneous push and pop
        rx_take("R2 rx order");
        rx_push = 1'b1; rx_push_data = 8'h99; rx_q.push_back(8'h99);
        rx_take("R10 head on push+pop");
        rx_push = 1'b0;
        chk("R10 level kept", rx_level, DEPTH - 1);
        for (int i = 0; i < DEPTH - 1; i++) rx_take("R2 rx order");
        chk("R2 rx empty", rx_level, 0);

        // R5 set outranks clear in the same cycle
        clr_wr = 1'b1; clr_bits = 4'b0010;
        rx_take("R4 rx empty data");
        clr_wr = 1'b0; clr_bits = '0;
        chk("R5 set wins", raw_irq[2], 1);
        clear(4'b0010);
        chk("R5 unf cleared", raw_irq[2], 0);

        // R9 busy bit
        engine_busy = 1'b1;
        #1;
        chk("R9 busy", status[0], 1);
        engine_busy = 1'b0;
        #1;
        chk("R9 idle", status[0], 0);

        @(negedge clk);
        wrap_up();
    end

endmodule